// File: doc/BRIEF.md
# Output Driver Fault Protection Controller

This controller decides, cycle by cycle, whether the power-stage output drivers of an audio amplifier may switch. It receives digitized fault flags from analog comparators (over-temperature trip, temperature-safe, output short, supply low, supply critical) and an enable from the power-up sequencer. It produces one driver enable plus a sticky status bit per fault class.

Each fault class follows its own policy. A short must persist for a qualification window before it counts. The drivers are then held off for a fixed hiccup time and re-armed, and the loop repeats while the short is present. An over-temperature trip turns the drivers off at once. They come back only after the safe flag has held without a break for a hold window. A low supply gates the drivers only for as long as it lasts. A critical supply clears all fault timers and the lower fault status, as a full reset would. All flags pass through a parameterized synchronizer. All windows are parameters in clock cycles, and their defaults are derived from the clock frequency.

Top module: `fpc_out_protect`

## Requirements
- R1: After reset all four status outputs are 0 and, with no flag raised and the sequencer enable high, `drv_en_o` is 1.
- R2: `drv_en_o` is 0 in the same cycle that `seq_en_i` is 0, with no register in between.
- R3: A short counts as qualified only after `short_i` has been seen high for QUAL_CYC consecutive synchronized cycles. A pulse that lasts QUAL_CYC-1 cycles leaves `drv_en_o` high and restarts the count. With SYNC_STAGES=S, a held short drops `drv_en_o` exactly S+QUAL_CYC edges after it is raised.
- R4: A qualified short holds `drv_en_o` low for exactly OFF_CYC cycles, after which it returns high. If the short persists, `drv_en_o` drops again QUAL_CYC cycles later, and this repeats until the short clears.
- R5: Raising `hot_i` drops `drv_en_o` S edges later. The thermal fault stays latched after `hot_i` falls.
- R6: After a thermal trip, `drv_en_o` returns only once `cool_i` is high and `hot_i` is low for HOLD_CYC consecutive synchronized cycles, which is S+HOLD_CYC edges after that condition begins. Any break restarts the count.
- R7: `uv_i` drops `drv_en_o` S edges after it rises and releases it S edges after it falls, with no timer involved.
- R8: While the synchronized `crit_i` is high, `drv_en_o` is 0, the short and thermal state machines return to idle, and `sts_short_o`, `sts_hot_o` and `sts_uv_o` are cleared. A latched thermal fault is therefore gone once `crit_i` falls.
- R9: `sts_short_o`, `sts_hot_o`, `sts_uv_o` and `sts_crit_o` are set by a qualified short, a synchronized `hot_i`, a synchronized `uv_i` and a synchronized `crit_i` respectively. They stay set until reset, or until a critical supply event for the first three.
- R10: Every fault flag passes through SYNC_STAGES register stages before any decision; with 0 stages the flags are used directly.

Ports table below lists the top module in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_en_i | input | 1 | Enable from the power-up sequencer |
| hot_i | input | 1 | Junction over-temperature trip flag |
| cool_i | input | 1 | Temperature below recovery point flag |
| short_i | input | 1 | Output over-current flag |
| uv_i | input | 1 | Supply below driver-gating level |
| crit_i | input | 1 | Supply below critical reset level |
| drv_en_o | output | 1 | Output driver enable |
| sts_short_o | output | 1 | Sticky: qualified short seen |
| sts_hot_o | output | 1 | Sticky: over-temperature seen |
| sts_uv_o | output | 1 | Sticky: low supply seen |
| sts_crit_o | output | 1 | Sticky: critical supply seen |

## Verification
The bench aims at the edges of each window. A short pulse one cycle under the qualification length must never trip; a counter that failed to clear between pulses would trip on the second one. The hiccup off time and the re-trip window are checked to the exact edge, which exposes any off-by-one in either counter. A thermal recovery with a break in the safe flag must stay off past the point where an unbroken count would have released, and a design that did not restart its count would release early. Finally, a critical supply event during a latched thermal fault must free the drivers without any safe indication; a design that only gated the enable would leave them stuck off.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   localparam int FLAG_N   = 5;
   localparam int IX_HOT   = 0;
   localparam int IX_COOL  = 1;
   localparam int IX_SHORT = 2;
   localparam int IX_UV    = 3;
   localparam int IX_CRIT  = 4;

   typedef enum logic {SG_RUN = 1'b0, SG_OFF = 1'b1} sg_state_e;
   typedef enum logic {TG_COOL = 1'b0, TG_HOT = 1'b1} tg_state_e;
endpackage

// File: rtl/fpc_flag_sync.sv
module fpc_flag_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("fpc_flag_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fpc_short_guard.sv
module fpc_short_guard
   import fpc_pkg::*;
#(
   parameter int QUAL_CYC = 700,
   parameter int OFF_CYC  = 2350000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic sc_i,
   output logic off_o
);
   localparam int MAXC  = (QUAL_CYC > OFF_CYC) ? QUAL_CYC : OFF_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_CYC - 1);
   localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_CYC - 1);

   generate
      if (QUAL_CYC < 2 || OFF_CYC < 2) begin : g_bad
         $error("fpc_short_guard: windows must be at least 2 cycles");
      end
   endgenerate

   sg_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SG_RUN;
         cnt_q <= '0;
      end else if (clr_i) begin
         st_q  <= SG_RUN;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SG_RUN: begin
               if (!sc_i) begin
                  cnt_q <= '0;
               end else if (cnt_q == QUAL_LAST) begin
                  st_q  <= SG_OFF;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (cnt_q == OFF_LAST) begin
                  st_q  <= SG_RUN;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign off_o = (st_q == SG_OFF);

   AST_OFF_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(off_o) |-> $past(sc_i)); // R3
   AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (off_o && !clr_i && cnt_q < OFF_LAST) |=> off_o); // R4
   AST_CLR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !off_o); // R8
endmodule

// File: rtl/fpc_thermal_guard.sv
module fpc_thermal_guard
   import fpc_pkg::*;
#(
   parameter int HOLD_CYC = 2350000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic trip_i,
   input  logic safe_i,
   output logic off_o
);
   localparam int CNT_W = $clog2(HOLD_CYC + 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

   generate
      if (HOLD_CYC < 2) begin : g_bad
         $error("fpc_thermal_guard: HOLD_CYC must be at least 2");
      end
   endgenerate

   tg_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             calm;

   assign calm = safe_i && !trip_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TG_COOL;
         cnt_q <= '0;
      end else if (clr_i) begin
         st_q  <= TG_COOL;
         cnt_q <= '0;
      end else begin
         case (st_q)
            TG_COOL: begin
               cnt_q <= '0;
               if (trip_i) st_q <= TG_HOT;
            end
            default: begin
               if (!calm) begin
                  cnt_q <= '0;
               end else if (cnt_q == HOLD_LAST) begin
                  st_q  <= TG_COOL;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign off_o = (st_q == TG_HOT) || trip_i;

   AST_TRIP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_i && !clr_i) |=> (st_q == TG_HOT)); // R5
   AST_HOT_WHILE_UNSAFE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == TG_HOT) && !calm && !clr_i) |=> (st_q == TG_HOT)); // R6
endmodule

// File: rtl/fpc_out_protect.sv
module fpc_out_protect
   import fpc_pkg::*;
#(
   parameter int CLK_HZ      = 50000000,
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYC    = CLK_HZ / 1000000 * 14,
   parameter int OFF_CYC     = CLK_HZ / 1000 * 47,
   parameter int HOLD_CYC    = CLK_HZ / 1000 * 47
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seq_en_i,
   input  logic hot_i,
   input  logic cool_i,
   input  logic short_i,
   input  logic uv_i,
   input  logic crit_i,
   output logic drv_en_o,
   output logic sts_short_o,
   output logic sts_hot_o,
   output logic sts_uv_o,
   output logic sts_crit_o
);
   logic [FLAG_N-1:0] raw_flags, syn_flags;
   logic hot_s, cool_s, short_s, uv_s, crit_s;
   logic sc_off, th_off;

   assign raw_flags[IX_HOT]   = hot_i;
   assign raw_flags[IX_COOL]  = cool_i;
   assign raw_flags[IX_SHORT] = short_i;
   assign raw_flags[IX_UV]    = uv_i;
   assign raw_flags[IX_CRIT]  = crit_i;

   fpc_flag_sync #(.W(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_flags), .q_o(syn_flags)
   );

   assign hot_s   = syn_flags[IX_HOT];
   assign cool_s  = syn_flags[IX_COOL];
   assign short_s = syn_flags[IX_SHORT];
   assign uv_s    = syn_flags[IX_UV];
   assign crit_s  = syn_flags[IX_CRIT];

   fpc_short_guard #(.QUAL_CYC(QUAL_CYC), .OFF_CYC(OFF_CYC)) u_short (
      .clk(clk), .rst_n(rst_n), .clr_i(crit_s), .sc_i(short_s), .off_o(sc_off)
   );

   fpc_thermal_guard #(.HOLD_CYC(HOLD_CYC)) u_therm (
      .clk(clk), .rst_n(rst_n), .clr_i(crit_s), .trip_i(hot_s),
      .safe_i(cool_s), .off_o(th_off)
   );

   assign drv_en_o = seq_en_i && !sc_off && !th_off && !uv_s && !crit_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_short_o <= 1'b0;
         sts_hot_o   <= 1'b0;
         sts_uv_o    <= 1'b0;
         sts_crit_o  <= 1'b0;
      end else if (crit_s) begin
         sts_short_o <= 1'b0;
         sts_hot_o   <= 1'b0;
         sts_uv_o    <= 1'b0;
         sts_crit_o  <= 1'b1;
      end else begin
         sts_short_o <= sts_short_o | sc_off;
         sts_hot_o   <= sts_hot_o | hot_s;
         sts_uv_o    <= sts_uv_o | uv_s;
      end
   end

   AST_UV_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      uv_s |-> !drv_en_o); // R7
   AST_CRIT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      crit_s |=> (!sts_hot_o && !sts_short_o && !sts_uv_o && sts_crit_o)); // R8
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_hot_o && !crit_s) |=> sts_hot_o); // R9
   AST_SEQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_en_i |-> !drv_en_o); // R2
endmodule

// File: tb/tb_fpc_out_protect.sv
`timescale 1ns/1ps
module tb_fpc_out_protect;
   localparam int S    = 2;
   localparam int QUAL = 4;
   localparam int OFFC = 20;
   localparam int HOLD = 12;

   logic clk = 1'b0;
   logic rst_n, seq_en, hot, cool, shrt, uv, crit;
   logic drv_en, s_short, s_hot, s_uv, s_crit;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   fpc_out_protect #(.CLK_HZ(100000000), .SYNC_STAGES(S), .QUAL_CYC(QUAL),
                     .OFF_CYC(OFFC), .HOLD_CYC(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .seq_en_i(seq_en), .hot_i(hot), .cool_i(cool),
      .short_i(shrt), .uv_i(uv), .crit_i(crit), .drv_en_o(drv_en),
      .sts_short_o(s_short), .sts_hot_o(s_hot), .sts_uv_o(s_uv), .sts_crit_o(s_crit)
   );

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic drive_at_negedge();
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; seq_en = 1; hot = 0; cool = 1; shrt = 0; uv = 0; crit = 0;
      edges(2);
      @(negedge clk); rst_n = 1;
      edges(S + 2);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk(drv_en, 1'b1, "R1", "drv_en after reset");
      chk(s_short | s_hot | s_uv | s_crit, 1'b0, "R1", "status after reset");
   endtask

   task automatic t_seq_gate();
      do_reset();
      drive_at_negedge(); seq_en = 0; #1;
      chk(drv_en, 1'b0, "R2", "drv_en same cycle seq_en low");
      drive_at_negedge(); seq_en = 1; #1;
      chk(drv_en, 1'b1, "R2", "drv_en back with seq_en");
   endtask

   task automatic t_short_pulse();
      do_reset();
      for (int p = 0; p < 2; p++) begin
         drive_at_negedge(); shrt = 1;
         edges(QUAL - 1);
         @(negedge clk); shrt = 0;
         edges(S + 3);
         chk(drv_en, 1'b1, "R3", "pulse of QUAL-1 must not trip");
      end
      chk(s_short, 1'b0, "R3", "no status after sub-window pulses");
   endtask

   task automatic t_short_hiccup();
      do_reset();
      drive_at_negedge(); shrt = 1;
      edges(S + QUAL - 1);
      chk(drv_en, 1'b1, "R3", "still on one edge before qualify");
      edges(1);
      chk(drv_en, 1'b0, "R3", "off after S+QUAL edges");
      edges(OFFC - 1);
      chk(drv_en, 1'b0, "R4", "still off at OFF-1");
      edges(1);
      chk(drv_en, 1'b1, "R4", "re-enabled after OFF cycles");
      edges(QUAL - 1);
      chk(drv_en, 1'b1, "R4", "on during retry window");
      edges(1);
      chk(drv_en, 1'b0, "R4", "re-trip after QUAL");
      chk(s_short, 1'b1, "R9", "short status set");
      @(negedge clk); shrt = 0;
      edges(OFFC + S + 2);
      chk(drv_en, 1'b1, "R4", "on after short clears");
      chk(s_short, 1'b1, "R9", "short status sticky");
   endtask

   task automatic t_thermal();
      do_reset();
      drive_at_negedge(); hot = 1; cool = 0;
      edges(S - 1);
      chk(drv_en, 1'b1, "R5", "on before sync latency");
      edges(1);
      chk(drv_en, 1'b0, "R5", "off S edges after trip");
      edges(8);
      @(negedge clk); hot = 0;
      edges(S + HOLD + 4);
      chk(drv_en, 1'b0, "R5", "latched without safe flag");
      @(negedge clk); cool = 1;
      edges(S + HOLD - 1);
      chk(drv_en, 1'b0, "R6", "off one edge before hold done");
      edges(1);
      chk(drv_en, 1'b1, "R6", "on after hold");
      chk(s_hot, 1'b1, "R9", "thermal status sticky");
   endtask

   task automatic t_thermal_break();
      do_reset();
      drive_at_negedge(); hot = 1; cool = 0;
      edges(6);
      @(negedge clk); hot = 0; cool = 1;
      edges(6);
      @(negedge clk); cool = 0;
      edges(3);
      @(negedge clk); cool = 1;
      edges(5);
      chk(drv_en, 1'b0, "R6", "off where unbroken count would release");
      edges(S + HOLD - 1 - 5);
      chk(drv_en, 1'b0, "R6", "off one edge before restarted hold");
      edges(1);
      chk(drv_en, 1'b1, "R6", "on after restarted hold");
   endtask

   task automatic t_uv();
      do_reset();
      drive_at_negedge(); uv = 1;
      edges(S - 1);
      chk(drv_en, 1'b1, "R7", "on before uv latency");
      edges(1);
      chk(drv_en, 1'b0, "R7", "off S edges after uv");
      edges(5);
      @(negedge clk); uv = 0;
      edges(S - 1);
      chk(drv_en, 1'b0, "R10", "still off inside sync latency");
      edges(1);
      chk(drv_en, 1'b1, "R7", "on S edges after uv clears");
      chk(s_uv, 1'b1, "R9", "uv status sticky");
   endtask

   task automatic t_crit();
      do_reset();
      drive_at_negedge(); hot = 1; cool = 0; uv = 1;
      edges(6);
      @(negedge clk); hot = 0; uv = 0;
      edges(6);
      chk(drv_en, 1'b0, "R5", "thermal latched before crit");
      @(negedge clk); crit = 1;
      edges(S + 2);
      chk(drv_en, 1'b0, "R8", "off during crit");
      chk(s_hot, 1'b0, "R8", "thermal status cleared by crit");
      chk(s_uv, 1'b0, "R8", "uv status cleared by crit");
      chk(s_crit, 1'b1, "R9", "crit status set");
      @(negedge clk); crit = 0;
      edges(S);
      chk(drv_en, 1'b1, "R8", "thermal latch gone after crit");
      chk(s_crit, 1'b1, "R9", "crit status sticky");
   endtask

   initial begin
      rst_n = 0; seq_en = 1; hot = 0; cool = 1; shrt = 0; uv = 0; crit = 0;
      t_reset_state();
      t_seq_gate();
      t_short_pulse();
      t_short_hiccup();
      t_thermal();
      t_thermal_break();
      t_uv();
      t_crit();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 50000; i++) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule